// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a short burst. A full start address is loaded on a load cycle. After that, every advance cycle moves to the next beat without a new address. Only the two lowest address bits follow the burst order. A burst therefore covers four beats before the order repeats, and the upper bits keep the loaded value.

The ordering flag is sampled on the load cycle. It selects one of two orders. In linear order the low bits wrap by adding the beat index modulo 4. In interleaved order the low bits are the start bits XORed with the beat index. The access direction (read or write) is also captured on the load cycle and held for every beat that follows. On advance cycles the chip-select and direction inputs are ignored. An active-low clock enable freezes all state.

The control is a three-state machine:
- **ST_IDLE**: no burst in progress.
- **ST_READ**: a read burst is active.
- **ST_WRITE**: a write burst is active.

The transitions, all taken on a cycle where the clock enable is active (low), are:
- **T_LOAD_RD** (any state to ST_READ): load cycle with chip select high and `wr_req` low.
- **T_LOAD_WR** (any state to ST_WRITE): load cycle with chip select high and `wr_req` high.
- **T_DESEL** (any state to ST_IDLE): load cycle with chip select low.
- **T_STEP** (self-loop): advance cycle. The beat index steps and the state is unchanged.
- **T_HOLD** (self-loop): the clock enable is high, so nothing changes.

Top module: `burst_seq`

## Requirements
- R1: During a burst, `cur_addr[ADDR_W-1:2]` keeps the upper bits of the loaded start address. Advance cycles never change them.
- R2: If `mode_ilv` was 0 at load, `cur_addr[1:0]` equals (start[1:0] + beat) mod 4.
- R3: If `mode_ilv` was 1 at load, `cur_addr[1:0]` equals start[1:0] XOR beat.
- R4: A load happens on a cycle with `clk_en_n`=0, `advance`=0 and `chip_sel`=1. From the next cycle, `cur_addr` equals the start address (beat 0) and `burst_active`=1.
- R5: A cycle with `clk_en_n`=0 and `advance`=1 steps the beat index by one, whatever the levels of `chip_sel` and `wr_req`.
- R6: `burst_wr` takes the value of `wr_req` on the load cycle and holds it through every advance cycle.
- R7: The beat index wraps modulo 4, so the fifth beat address equals the first.
- R8: While `clk_en_n`=1, `cur_addr`, `burst_active` and `burst_wr` hold their values whatever the other inputs do.
- R9: A cycle with `clk_en_n`=0, `advance`=0 and `chip_sel`=0 deselects. From the next cycle, `burst_active`=0 and `burst_wr`=0, and `cur_addr` holds its value.
- R10: After reset, `cur_addr`=0, `burst_active`=0 and `burst_wr`=0.
- R11: A change of `mode_ilv` between loads has no effect on the order of the current burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes all state |
| advance | input | 1 | 1 = advance to next beat, 0 = load or deselect |
| chip_sel | input | 1 | Combined chip select, qualifies a load |
| wr_req | input | 1 | Direction at load, 1 = write |
| mode_ilv | input | 1 | Order at load, 1 = interleaved, 0 = linear |
| start_addr | input | ADDR_W | Start address taken on load |
| cur_addr | output | ADDR_W | Address of the current beat |
| burst_active | output | 1 | A burst is in progress |
| burst_wr | output | 1 | Held direction of the current burst |

## Verification
The bench loads every start value of the low bits in both orders and then advances past four beats. A wrong wrap, a carry into the upper bits, or linear and XOR swapped would show as a wrong address on some beat. During advances it toggles chip select, direction and the ordering input, and during freeze cycles it offers a full load. A design that reads those inputs outside a load cycle would change direction or order mid-burst, or would step while frozen. Deselect cycles catch a design that stays active after a load with chip select low, or that loses the held address.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bseq_state_e;

endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [BEAT_W-1:0] beat
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (clr) begin
            beat <= '0;
        end else if (step) begin
            beat <= beat + 1'b1;
        end
    end

    AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> beat == BEAT_W'($past(beat) + 1'b1))
        else $error("beat step/wrap broken"); // R7

    AST_BEAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> beat == '0)
        else $error("beat not cleared on load"); // R4

endmodule

// File: rtl/bseq_ctrl_fsm.sv
module bseq_ctrl_fsm
    import bseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic advance,
    input  logic chip_sel,
    input  logic wr_req,
    output logic load,
    output logic step,
    output logic burst_active,
    output logic burst_wr
);

    bseq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (en && !advance) begin
            unique case ({chip_sel, wr_req})
                2'b11:   state_d = ST_WRITE;
                2'b10:   state_d = ST_READ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load = en && !advance && chip_sel;
        step = en && advance;
        unique case (state_q)
            ST_READ: begin
                burst_active = 1'b1;
                burst_wr     = 1'b0;
            end
            ST_WRITE: begin
                burst_active = 1'b1;
                burst_wr     = 1'b1;
            end
            default: begin
                burst_active = 1'b0;
                burst_wr     = 1'b0;
            end
        endcase
    end

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && advance) |=> (burst_wr == $past(burst_wr)) && (burst_active == $past(burst_active)))
        else $error("direction changed on advance"); // R6

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !advance && !chip_sel) |=> (!burst_active && !burst_wr))
        else $error("deselect did not idle"); // R9

    AST_LOAD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !advance && chip_sel) |=> (burst_active && burst_wr == $past(wr_req)))
        else $error("direction not captured"); // R6

endmodule

// File: rtl/bseq_order.sv
module bseq_order
    import bseq_pkg::*;
(
    input  logic              interleave,
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] addr_lo
);

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    assign lin_lo = start_lo + beat;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_lo[b] = start_lo[b] ^ beat[b];
    end

    assign addr_lo = interleave ? ilv_lo : lin_lo;

    always_comb begin
        if (beat == '0) begin
            AST_BEAT0_START: assert (addr_lo == start_lo)
                else $error("beat 0 not start"); // R2
        end
    end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              advance,
    input  logic              chip_sel,
    input  logic              wr_req,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              burst_active,
    output logic              burst_wr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              en;
    logic              load;
    logic              step;
    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] base_q;
    logic              mode_q;
    logic [BEAT_W-1:0] addr_lo;

    assign en = !clk_en_n;

    bseq_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .advance      (advance),
        .chip_sel     (chip_sel),
        .wr_req       (wr_req),
        .load         (load),
        .step         (step),
        .burst_active (burst_active),
        .burst_wr     (burst_wr)
    );

    bseq_beat_ctr u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .step  (step),
        .beat  (beat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mode_q <= 1'b0;
        end else if (load) begin
            base_q <= start_addr;
            mode_q <= mode_ilv;
        end
    end

    bseq_order u_order (
        .interleave (mode_q),
        .start_lo   (base_q[BEAT_W-1:0]),
        .beat       (beat),
        .addr_lo    (addr_lo)
    );

    assign cur_addr = {base_q[ADDR_W-1:BEAT_W], addr_lo};

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !advance && chip_sel) |=> cur_addr == $past(start_addr))
        else $error("load address wrong"); // R4

    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && advance) |=> cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W]))
        else $error("upper bits moved"); // R1

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(cur_addr) && $stable(burst_active) && $stable(burst_wr)))
        else $error("state moved while frozen"); // R8

    AST_DESEL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !advance && !chip_sel) |=> $stable(cur_addr))
        else $error("address moved on deselect"); // R9

    if (HI_W < 1) begin : g_bad_width
        initial $error("ADDR_W must exceed the beat width");
    end

endmodule

// File: tb/burst_seq_tb.sv
`timescale 1ns/1ps
module burst_seq_tb;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b1;
    logic          advance = 1'b0;
    logic          chip_sel = 1'b0;
    logic          wr_req = 1'b0;
    logic          mode_ilv = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] cur_addr;
    logic          burst_active;
    logic          burst_wr;

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference
    int  m_base = 0;
    int  m_beat = 0;
    bit  m_mode = 0;
    bit  m_act  = 0;
    bit  m_wr   = 0;

    always #2 clk = ~clk;

    burst_seq #(.ADDR_W(AW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en_n     (clk_en_n),
        .advance      (advance),
        .chip_sel     (chip_sel),
        .wr_req       (wr_req),
        .mode_ilv     (mode_ilv),
        .start_addr   (start_addr),
        .cur_addr     (cur_addr),
        .burst_active (burst_active),
        .burst_wr     (burst_wr)
    );

    always @(posedge clk) begin
        if (rst_n && !clk_en_n) begin
            if (!advance) begin
                if (chip_sel) begin
                    m_base = int'(start_addr);
                    m_beat = 0;
                    m_mode = mode_ilv;
                    m_act  = 1;
                    m_wr   = wr_req;
                end else begin
                    m_act = 0;
                    m_wr  = 0;
                end
            end else begin
                m_beat = (m_beat + 1) % 4;
            end
        end
    end

    function automatic int exp_addr();
        int lo;
        lo = m_base % 4;
        if (m_mode) lo = lo ^ m_beat;
        else        lo = (lo + m_beat) % 4;
        return (m_base / 4) * 4 + lo;
    endfunction

    task automatic check(input string tag);
        int ea;
        ea = exp_addr();
        n_chk++;
        if (int'(cur_addr) != ea || burst_active != m_act || burst_wr != m_wr) begin
            n_bad++;
            $display("FAIL %s: addr=%h act=%0d wr=%0d expected addr=%h act=%0d wr=%0d",
                     tag, cur_addr, burst_active, burst_wr, ea[AW-1:0], m_act, m_wr);
        end
    endtask

    // drive at negedge, wait one cycle, then compare at the next negedge
    task automatic cyc(input bit en_n, input bit adv, input bit sel, input bit wr,
                       input bit md, input logic [AW-1:0] a, input string tag);
        clk_en_n   = en_n;
        advance    = adv;
        chip_sel   = sel;
        wr_req     = wr;
        mode_ilv   = md;
        start_addr = a;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        repeat (3) @(negedge clk);
        check("R10 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after release");

        // every start value in both orders, five beats to show wrap
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                a = AW'((s * 37 + md * 1000 + 12) * 4 + s);
                cyc(0, 0, 1, 1'(s & 1), 1'(md), a, "R4 load");
                for (int k = 0; k < 5; k++) begin
                    cyc(0, 1, 1'(k & 1), 1'((k + s) & 1), 1'(k & 1) ^ 1'(md), ~a,
                        md ? "R3 R5 R6 R11 interleaved beat" : "R2 R5 R6 R11 linear beat");
                end
                check("R7 R1 wrap beat");
            end
        end

        // freeze mid-burst while a full load is offered
        cyc(0, 0, 1, 1, 0, 16'h1232, "R4 load");
        cyc(0, 1, 0, 0, 1, 16'h0000, "R2 beat");
        for (int k = 0; k < 4; k++) begin
            cyc(1, 1'(k & 1), 1, 1'(k & 1), 1, 16'hFFFF, "R8 frozen");
        end
        cyc(0, 1, 0, 0, 1, 16'h0000, "R2 R8 resume");

        // deselect, then advance while idle, then frozen deselect
        cyc(0, 0, 0, 1, 1, 16'hAAAA, "R9 deselect");
        cyc(0, 1, 1, 1, 1, 16'h5555, "R5 R9 advance idle");
        cyc(0, 0, 1, 0, 1, 16'hBEE1, "R4 R3 load read");
        cyc(1, 0, 0, 1, 0, 16'h0000, "R8 frozen deselect");
        cyc(0, 1, 0, 1, 0, 16'h0000, "R3 R6 R11 beat");
        cyc(0, 1, 0, 1, 0, 16'h0000, "R3 R1 beat");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule